// File: doc/BRIEF.md
# Multi-Source Event Framer

The framer gathers one serial record from each of a set of front-end sources and turns the set into a single framed event made of 32-bit words. Each source delivers a 71-bit record, most significant bit first, through its own serial bit and valid strobe. The record holds 64 data bits, a 4-bit local bunch counter and a 3-bit local event counter. Sources may deliver at different rates. Once every source has a complete record, the framer compares each source's counters against the central bunch ID and event count. It then writes the frame into an internal output FIFO, which a downstream consumer drains one word per read strobe.

The frame opens with a fixed start word and carries the central counters, one mismatch flag per source, the source count and the data of every source. It closes with a fixed end word and a parity word for error checking at the receiver. The source shift registers are released at the end of each frame, so the next records can be shifted in while the FIFO is still draining.

Top module: `evt_framer`

## Requirements
- R1: Each source shifts its serial bit in on every clock with its valid high, most significant bit first. The 71-bit record is complete after 71 accepted bits. Its layout is bunch counter in bits [70:67], event counter in bits [66:64] and data in bits [63:0].
- R2: No frame word is produced and `frame_busy` stays low until every source has a complete record.
- R3: The frame is written in this order: 32'h5A5A0F0F; the central bunch ID zero-extended to 32 bits; the central event count zero-extended to 32 bits; the error-flag word; the number of sources; for sources 0 to N-1 in turn, data bits [63:32] and then data bits [31:0]; 32'hA5A50F0F; the parity word.
- R4: Bit i of the error-flag word is 1 exactly when source i's bunch counter differs from bits [3:0] of the central bunch ID, or its event counter differs from bits [2:0] of the central event count. Bits at or above the source count are 0. The central values are taken in the cycle framing starts.
- R5: The parity word is the bitwise XOR of every earlier word of the same frame, the start and end words included.
- R6: While the FIFO is full, word writes wait. No word is lost, duplicated or reordered, and the FIFO never holds more than its depth.
- R7: Bits offered to a source that already holds a complete record are ignored until its frame has been written.
- R8: When the last word of a frame is written, all sources are cleared and accept a new record, so frames follow one another without loss.
- R9: After reset the FIFO is empty, `frame_busy` is low and no source holds a record.
- R10: A read strobe while the FIFO is empty has no effect on the FIFO contents or on later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vld | input | N_SRC | Per-source strobe: the bit on `src_bit` is valid |
| src_bit | input | N_SRC | Per-source serial record bit |
| ref_bcid | input | 12 | Central bunch ID |
| ref_evcnt | input | 24 | Central event count |
| fifo_rd | input | 1 | Pop one word from the output FIFO |
| fifo_dout | output | 32 | Word at the head of the output FIFO |
| fifo_empty | output | 1 | Output FIFO holds no word |
| frame_busy | output | 1 | A frame is being written into the FIFO |

## Verification
A wrong word index or a wrong source select shows at the FIFO head as a misplaced header or data word, at the first word it affects. A bad counter comparison shows in the fourth word of that same frame. A stale parity accumulator shows in the last word. A shift register that is not cleared or that keeps accepting bits corrupts the data words of the following frame. A FIFO pointer slip under back-pressure or on an empty read shows as a duplicated or missing word within a few reads.

// File: rtl/evt_pkg.sv
// Shared constants and types for the multi-source event framer.
package evt_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] FRAME_SOF = 32'h5A5A_0F0F;
    localparam logic [WORD_W-1:0] FRAME_EOF = 32'hA5A5_0F0F;
    // Header words ahead of the per-source data: SOF, bcid, evcnt, flags, count
    localparam int HDR_WORDS = 5;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/evt_src_shreg.sv
// Receive shift register for one front-end source.
// Shifts MSB first on each valid strobe; flags complete after REC_W bits.
// Assumes: bits offered while complete are dropped; clr has priority.
module evt_src_shreg #(
    parameter int REC_W = 71
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic             bit_in,
    input  logic             clr,
    output logic [REC_W-1:0] rec,
    output logic             done
);
    localparam int CNT_W = $clog2(REC_W + 1);

    logic [CNT_W-1:0] cnt_q;

    // Shift accepted bits and count them up to a full record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec   <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (vld && !done) begin
            rec   <= {rec[REC_W-2:0], bit_in};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(REC_W - 1)) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_out_fifo.sv
// Output word FIFO, show-ahead read port.
// Assumes: DEPTH is a power of two; writes while full and reads while
// empty are dropped.
module evt_out_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [W-1:0]             din,
    input  logic                     rd,
    output logic [W-1:0]             dout,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_q;
    logic             wr_ok;
    logic             rd_ok;

    assign empty = (level == '0);
    assign full  = (level == (PTR_W+1)'(DEPTH));
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign dout  = mem[rp_q];

    // Store accepted words
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wp_q] <= din;
        end
    end

    // Track pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wp_q <= wp_q + 1'b1;
            if (rd_ok) rp_q <= rp_q + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/evt_frame_seq.sv
// Frame sequencer: waits for all records, latches the central counters,
// computes mismatch flags and writes the framed words in order.
// Assumes: N_SRC <= 32, DATA_W == 64; stalls while the FIFO is full.
module evt_frame_seq
    import evt_pkg::*;
#(
    parameter int N_SRC   = 25,
    parameter int DATA_W  = 64,
    parameter int LBC_W   = 4,
    parameter int LEV_W   = 3,
    parameter int BCID_W  = 12,
    parameter int EVCNT_W = 24,
    parameter int REC_W   = DATA_W + LBC_W + LEV_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        all_done,
    input  logic [N_SRC-1:0][REC_W-1:0] recs,
    input  logic [BCID_W-1:0]           ref_bcid,
    input  logic [EVCNT_W-1:0]          ref_evcnt,
    input  logic                        fifo_full,
    output logic                        push,
    output logic [WORD_W-1:0]           word,
    output logic                        busy,
    output logic                        clr
);
    localparam int FRAME_WORDS = HDR_WORDS + 2 * N_SRC + 2;
    localparam int EOF_IDX     = HDR_WORDS + 2 * N_SRC;
    localparam int LAST_IDX    = FRAME_WORDS - 1;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam int SRC_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    seq_state_t          state_q;
    logic [IDX_W-1:0]    idx_q;
    logic [WORD_W-1:0]   par_q;
    logic [BCID_W-1:0]   bcid_q;
    logic [EVCNT_W-1:0]  evcnt_q;
    logic [WORD_W-1:0]   err_q;
    logic [WORD_W-1:0]   err_c;
    logic [IDX_W-1:0]    k;
    logic [SRC_W-1:0]    src;
    logic                last;

    // Per-source counter comparison against the central reference
    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign err_c[g] =
            (recs[g][REC_W-1 -: LBC_W] != ref_bcid[LBC_W-1:0]) ||
            (recs[g][DATA_W+LEV_W-1 -: LEV_W] != ref_evcnt[LEV_W-1:0]);
    end
    if (N_SRC < WORD_W) begin : g_err_pad
        assign err_c[WORD_W-1:N_SRC] = '0;
    end

    assign busy = (state_q == SEQ_EMIT);
    assign push = busy && !fifo_full;
    assign last = (idx_q == IDX_W'(LAST_IDX));
    assign clr  = push && last;

    // Select the word for the current frame position
    always_comb begin
        k    = idx_q - IDX_W'(HDR_WORDS);
        src  = SRC_W'(k >> 1);
        word = par_q;
        if (idx_q == IDX_W'(0)) begin
            word = FRAME_SOF;
        end else if (idx_q == IDX_W'(1)) begin
            word = WORD_W'(bcid_q);
        end else if (idx_q == IDX_W'(2)) begin
            word = WORD_W'(evcnt_q);
        end else if (idx_q == IDX_W'(3)) begin
            word = err_q;
        end else if (idx_q == IDX_W'(4)) begin
            word = WORD_W'(N_SRC);
        end else if (idx_q < IDX_W'(EOF_IDX)) begin
            word = k[0] ? recs[src][WORD_W-1:0] : recs[src][DATA_W-1 -: WORD_W];
        end else if (idx_q == IDX_W'(EOF_IDX)) begin
            word = FRAME_EOF;
        end
    end

    // Frame state, position, parity accumulation and reference capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            par_q   <= '0;
            bcid_q  <= '0;
            evcnt_q <= '0;
            err_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (all_done) begin
                        state_q <= SEQ_EMIT;
                        idx_q   <= '0;
                        par_q   <= '0;
                        bcid_q  <= ref_bcid;
                        evcnt_q <= ref_evcnt;
                        err_q   <= err_c;
                    end
                end
                default: begin
                    if (!fifo_full) begin
                        par_q <= par_q ^ word;
                        if (last) begin
                            state_q <= SEQ_IDLE;
                            idx_q   <= '0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/evt_framer.sv
// Multi-source event framer top: per-source receive shift registers,
// frame sequencer and output FIFO.
// Assumes: central counters stay valid in the cycle all records complete.
module evt_framer #(
    parameter int N_SRC      = 25,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_vld,
    input  logic [N_SRC-1:0]  src_bit,
    input  logic [11:0]       ref_bcid,
    input  logic [23:0]       ref_evcnt,
    input  logic              fifo_rd,
    output logic [31:0]       fifo_dout,
    output logic              fifo_empty,
    output logic              frame_busy
);
    localparam int DATA_W = 64;
    localparam int LBC_W  = 4;
    localparam int LEV_W  = 3;
    localparam int REC_W  = DATA_W + LBC_W + LEV_W;
    localparam int LVL_W  = $clog2(FIFO_DEPTH) + 1;

    logic [N_SRC-1:0][REC_W-1:0] recs;
    logic [N_SRC-1:0]            src_done;
    logic                        all_done;
    logic                        src_clr;
    logic                        wr_push;
    logic [31:0]                 wr_word;
    logic                        fifo_full;
    logic [LVL_W-1:0]            fifo_cnt;

    // One receive shift register per source
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        evt_src_shreg #(.REC_W(REC_W)) u_sr (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (src_vld[g]),
            .bit_in (src_bit[g]),
            .clr    (src_clr),
            .rec    (recs[g]),
            .done   (src_done[g])
        );
    end

    assign all_done = &src_done;

    evt_frame_seq #(
        .N_SRC   (N_SRC),
        .DATA_W  (DATA_W),
        .LBC_W   (LBC_W),
        .LEV_W   (LEV_W),
        .BCID_W  (12),
        .EVCNT_W (24),
        .REC_W   (REC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .all_done  (all_done),
        .recs      (recs),
        .ref_bcid  (ref_bcid),
        .ref_evcnt (ref_evcnt),
        .fifo_full (fifo_full),
        .push      (wr_push),
        .word      (wr_word),
        .busy      (frame_busy),
        .clr       (src_clr)
    );

    evt_out_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_push),
        .din   (wr_word),
        .rd    (fifo_rd),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_cnt)
    );
endmodule

// File: rtl/evt_framer_chk.sv
// Protocol checker for the event framer, bound to the top module.
module evt_framer_chk #(
    parameter int N_SRC = 25,
    parameter int DEPTH = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fifo_rd,
    input logic                     fifo_empty,
    input logic                     frame_busy,
    input logic                     all_done,
    input logic [N_SRC-1:0]         done_vec,
    input logic                     push,
    input logic [$clog2(DEPTH):0]   fifo_cnt
);
    // FIFO level never exceeds its depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

    // Framing begins only after every source was complete
    assert_start_all_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_busy) |-> $past(all_done));

    // Records stay complete (and unchanged) for the whole frame
    assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_busy |-> all_done);

    // Frame end releases every source
    assert_clear_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_busy) |-> (done_vec == '0));

    // Reset leaves an empty FIFO and an idle sequencer
    assert_reset_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (fifo_empty && !frame_busy));

    // Reading an empty FIFO without a write keeps it empty
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_empty && !push) |=> fifo_empty);
endmodule

bind evt_framer evt_framer_chk #(.N_SRC(N_SRC), .DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_rd    (fifo_rd),
    .fifo_empty (fifo_empty),
    .frame_busy (frame_busy),
    .all_done   (all_done),
    .done_vec   (src_done),
    .push       (wr_push),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/evt_framer_bench.sv
`timescale 1ns/1ps
module evt_framer_bench;
    localparam int N  = 25;
    localparam int RW = 71;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   src_vld = '0;
    logic [N-1:0]   src_bit = '0;
    logic [11:0]    ref_bcid = '0;
    logic [23:0]    ref_evcnt = '0;
    logic           fifo_rd;
    logic [31:0]    fifo_dout;
    logic           fifo_empty;
    logic           frame_busy;

    logic           mon_rd = 1'b0;
    logic           test_rd = 1'b0;
    logic           slow = 1'b0;
    int             tick = 0;
    int             n_checks = 0;
    int             n_errors = 0;
    logic [31:0]    exp_q[$];
    string          tag_q[$];
    logic [RW-1:0]  rec_tb [N];

    assign fifo_rd = mon_rd | test_rd;

    always #5 clk = ~clk;

    evt_framer #(.N_SRC(N), .FIFO_DEPTH(8)) u_evt_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_vld    (src_vld),
        .src_bit    (src_bit),
        .ref_bcid   (ref_bcid),
        .ref_evcnt  (ref_evcnt),
        .fifo_rd    (fifo_rd),
        .fifo_dout  (fifo_dout),
        .fifo_empty (fifo_empty),
        .frame_busy (frame_busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver side: build records for frame f and queue the expected words
    task automatic build_frame(input int f, input int mode);
        logic [31:0] par;
        logic [31:0] flags;
        logic [3:0]  bc;
        logic [2:0]  ev;
        logic [31:0] hi;
        logic [31:0] lo;
        ref_bcid  = 12'h5C3 + 12'(f * 37);
        ref_evcnt = 24'h00A1B0 + 24'(f * 5);
        flags = '0;
        for (int s = 0; s < N; s++) begin
            bc = ref_bcid[3:0];
            ev = ref_evcnt[2:0];
            if (mode == 1) begin
                if (s == 0 || s == 24) bc = bc ^ 4'h8;
                if (s == 7 || s == 24) ev = ev ^ 3'h1;
            end else if (mode == 2) begin
                bc = bc ^ 4'((s % 15) + 1);
            end
            if (bc != ref_bcid[3:0] || ev != ref_evcnt[2:0]) flags[s] = 1'b1;
            hi = {8'(8'hD0 + f), 8'(s), 16'hBEEF ^ 16'(s * 131)};
            lo = 32'h1357_9BDF ^ (32'(s) << (f % 8)) ^ (32'(f) * 32'h0101_0101);
            rec_tb[s] = {bc, ev, hi, lo};
        end
        par = 32'h5A5A_0F0F;
        exp_q.push_back(32'h5A5A_0F0F); tag_q.push_back("R3 start word");
        exp_q.push_back({20'h0, ref_bcid}); tag_q.push_back("R3 bunch id word");
        par ^= {20'h0, ref_bcid};
        exp_q.push_back({8'h0, ref_evcnt}); tag_q.push_back("R3 event count word");
        par ^= {8'h0, ref_evcnt};
        exp_q.push_back(flags); tag_q.push_back("R4 mismatch flags");
        par ^= flags;
        exp_q.push_back(32'(N)); tag_q.push_back("R3 source count");
        par ^= 32'(N);
        for (int s = 0; s < N; s++) begin
            exp_q.push_back(rec_tb[s][63:32]); tag_q.push_back("R1 data high word");
            par ^= rec_tb[s][63:32];
            exp_q.push_back(rec_tb[s][31:0]); tag_q.push_back("R1 data low word");
            par ^= rec_tb[s][31:0];
        end
        exp_q.push_back(32'hA5A5_0F0F); tag_q.push_back("R3 end word");
        par ^= 32'hA5A5_0F0F;
        exp_q.push_back(par); tag_q.push_back(slow ? "R6 parity under stall" : "R5 parity word");
    endtask

    // Shift records in; gap slows odd sources, junk feeds completed ones (R7)
    task automatic send_frame(input bit gap, input bit junk);
        int  pos [N];
        int  cyc;
        bit  pending;
        bit  early_busy;
        for (int s = 0; s < N; s++) pos[s] = RW - 1;
        cyc = 0;
        pending = 1'b1;
        early_busy = 1'b0;
        while (pending) begin
            @(negedge clk);
            if (frame_busy) early_busy = 1'b1;
            pending = 1'b0;
            for (int s = 0; s < N; s++) begin
                if (pos[s] >= 0 && (!gap || (s % 2) == 0 || (cyc % 3) == 0)) begin
                    src_vld[s] = 1'b1;
                    src_bit[s] = rec_tb[s][pos[s]];
                    pos[s]--;
                end else if (pos[s] < 0 && junk) begin
                    src_vld[s] = 1'b1;
                    src_bit[s] = 1'(cyc ^ s);
                end else begin
                    src_vld[s] = 1'b0;
                end
                if (pos[s] >= 0) pending = 1'b1;
            end
            cyc++;
        end
        @(negedge clk);
        src_vld = '0;
        src_bit = '0;
        // R2: no framing while any source was still incomplete
        check(!early_busy, "R2 busy before all records", 32'(early_busy), 32'h0);
        do @(negedge clk); while (!frame_busy);
        do @(negedge clk); while (frame_busy);
    endtask

    // Monitor: pop FIFO words and compare against the scoreboard
    always @(negedge clk) begin
        tick <= tick + 1;
        mon_rd = 1'b0;
        if (rst_n && !fifo_empty && (!slow || (tick % 4) == 0)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected extra word", fifo_dout, 32'h0);
            end else begin
                check(fifo_dout === exp_q[0], tag_q[0], fifo_dout, exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            mon_rd = 1'b1;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_empty === 1'b1, "R9 fifo empty after reset", 32'(fifo_empty), 32'h1);
        check(frame_busy === 1'b0, "R9 idle after reset", 32'(frame_busy), 32'h0);
        repeat (5) @(negedge clk);
        check(fifo_empty === 1'b1, "R9 no frame without records", 32'(fifo_empty), 32'h1);

        // Frame 0: no mismatches, uniform shifting, fast reads
        build_frame(0, 0);
        send_frame(1'b0, 1'b0);

        // Frame 1: some mismatches, uneven rates, junk bits, slow reads (R6 stall)
        slow = 1'b1;
        build_frame(1, 1);
        send_frame(1'b1, 1'b1);

        // Frame 2: all sources mismatched, sent while frame 1 still drains (R8)
        build_frame(2, 2);
        send_frame(1'b0, 1'b1);
        slow = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        // R10: reads on an empty FIFO
        test_rd = 1'b1;
        repeat (3) @(negedge clk);
        test_rd = 1'b0;
        check(fifo_empty === 1'b1, "R10 empty after empty reads", 32'(fifo_empty), 32'h1);

        // Frame 3 after the empty reads
        build_frame(3, 0);
        send_frame(1'b1, 1'b0);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(fifo_empty === 1'b1, "R8 all frames drained", 32'(fifo_empty), 32'h1);
        check(exp_q.size() == 0, "R8 scoreboard empty", 32'(exp_q.size()), 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule